// File: doc/BRIEF.md
# Double-to-Int32 Conversion Unit

This unit takes a 64-bit IEEE-754 double and turns it into a signed 32-bit integer. The integer goes in the low half of a 64-bit result word, and the constant 0xFFF80000 goes in the upper half. A conversion starts with a single-cycle start strobe. One cycle later the unit gives either a result-write pulse or an exception-request pulse, and it updates a small set of status flags at the same time.

There are two variants of the operation, chosen by a truncate-select input. With truncate-select low, the conversion uses the rounding mode on a 2-bit input. With truncate-select high, it always rounds toward zero. Operands that cannot be represented are invalid. These are NaNs, infinities, and finite values outside the signed 32-bit range judged before any rounding. An invalid operand is either written as a fixed saturation pattern or reported as an exception with no write. An invalid-enable input selects which.

Top module: `dbl_to_int32_unit`

## Requirements
- R1: While reset is asserted, and after it is released, result_o is zero, status_o is zero and both pulse outputs are low.
- R2: A start strobe gives, one clock later, exactly one of wr_en_o or exc_req_o for a single cycle. result_o changes only in a cycle where wr_en_o is high.
- R3: For an in-range operand, result_o[31:0] is the rounded integer in two's complement and result_o[63:32] is 0xFFF80000.
- R4: With truncate-select low, rounding follows rmode_i. 0 rounds to nearest with ties to even, 1 rounds toward zero, 2 rounds toward +infinity, and 3 rounds toward -infinity.
- R5: With truncate-select high, the conversion rounds toward zero whatever rmode_i holds.
- R6: On an in-range conversion, status_o[1] (inexact) is set if the result differs from the operand, and status_o[0] (rounded-up) is set if the magnitude was increased. Each conversion overwrites both bits, so both are 0 when the conversion is exact.
- R7: A NaN operand (exponent all ones, fraction nonzero) clears status_o[1:0] and sets status_o[2] (invalid conversion) and status_o[4] (invalid summary). If operand bit 51 is zero, the NaN is signaling and status_o[3] is set as well.
- R8: A non-NaN operand above 2^31-1 or below -2^31 is out of range, and this includes both infinities. The test uses the unrounded value. It clears status_o[1:0] and sets status_o[2] and status_o[4].
- R9: With inv_en_i low, an invalid operand writes 0xFFF800007FFFFFFF if it is a positive out-of-range value. Any other invalid operand writes 0xFFF8000080000000.
- R10: With inv_en_i high, an invalid operand raises exc_req_o and sets status_o[5] (exception summary). wr_en_o stays low and result_o keeps its previous value.
- R11: status_o[5:2] are sticky. Once set, they stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a conversion of the current operand |
| operand_i | input | 64 | Double-precision operand |
| rmode_i | input | 2 | Rounding mode used when truncation is not selected |
| trunc_i | input | 1 | Forces rounding toward zero |
| inv_en_i | input | 1 | Invalid-operation trap enable |
| result_o | output | 64 | Registered conversion result |
| wr_en_o | output | 1 | Single-cycle result-write pulse |
| exc_req_o | output | 1 | Single-cycle exception request |
| status_o | output | 6 | Status flags, bit order given in R6 to R11 |

## Verification
The same clock edge carries both a result update and a status update. The case that needs care is an invalid operand while sticky bits from earlier conversions are already set. In that cycle the rounded-up and inexact bits must clear, the invalid bits must be added to the sticky bits, and the write or trap must be decided. The bench provokes this by running signaling NaNs, quiet NaNs and boundary values straight after inexact in-range conversions, with the trap both enabled and disabled. It compares the full result word, both pulses and all six flags against a model that keeps its own copy of the sticky state and of the last written result.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int DW      = 64;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int INT_W   = 32;
  localparam int BIAS    = 1023;
  localparam int FIX_F   = 64;
  localparam int FIX_W   = INT_W + FIX_F;
  localparam int SH_OFF  = FIX_F - FRAC_W;
  localparam int SH_W    = $clog2(FIX_W);
  localparam int EW      = EXP_W + 2;
  localparam int STAT_W  = 6;
  localparam logic [INT_W-1:0] SAT_HI  = 32'hFFF8_0000;
  localparam logic [INT_W-1:0] SAT_POS = 32'h7FFF_FFFF;
  localparam logic [INT_W-1:0] SAT_NEG = 32'h8000_0000;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic exc_sum;
    logic inv_any;
    logic inv_snan;
    logic inv_conv;
    logic inexact;
    logic rounded;
  } stat_t;
endpackage

// File: rtl/cvt_classify.sv
module cvt_classify
  import cvt_pkg::*;
(
  input  logic [DW-1:0]    op_i,
  output logic             sign_o,
  output logic             nan_o,
  output logic             snan_o,
  output logic             out_rng_o,
  output logic [INT_W-1:0] mag_o,
  output logic             rbit_o,
  output logic             sticky_o
);
  localparam logic signed [EW-1:0] E_LO  = -(EW'(1));
  localparam logic signed [EW-1:0] E_HI  = EW'(INT_W - 1);
  localparam logic signed [EW-1:0] E_BIA = EW'(BIAS);
  localparam logic signed [EW-1:0] E_OFF = EW'(SH_OFF);

  logic [EXP_W-1:0]      exp_f;
  logic [FRAC_W-1:0]     frac_f;
  logic                  exp_max;
  logic signed [EW-1:0]  e_unb;
  logic signed [EW-1:0]  sh_full;
  logic [SIG_W-1:0]      sig;
  logic [FIX_W-1:0]      fx;
  logic                  huge;
  logic                  frac_any;
  logic                  pos_over;
  logic                  neg_over;

  always_comb begin
    exp_f    = op_i[DW-2 -: EXP_W];
    frac_f   = op_i[FRAC_W-1:0];
    sign_o   = op_i[DW-1];
    exp_max  = &exp_f;
    nan_o    = exp_max && (|frac_f);
    snan_o   = nan_o && !frac_f[FRAC_W-1];
    e_unb    = $signed({2'b00, exp_f}) - E_BIA;
    sig      = {|exp_f, frac_f};
    sh_full  = e_unb + E_OFF;
    huge     = exp_max || (e_unb > E_HI);
    fx       = '0;
    mag_o    = '0;
    rbit_o   = 1'b0;
    sticky_o = 1'b0;
    if (!huge && (e_unb >= E_LO)) begin
      fx       = {{(FIX_W-SIG_W){1'b0}}, sig} << sh_full[SH_W-1:0];
      mag_o    = fx[FIX_W-1 -: INT_W];
      rbit_o   = fx[FIX_F-1];
      sticky_o = |fx[FIX_F-2:0];
    end else if (!huge) begin
      sticky_o = |sig;
    end
    frac_any  = rbit_o | sticky_o;
    pos_over  = mag_o[INT_W-1] || ((mag_o == SAT_POS) && frac_any);
    neg_over  = (mag_o > SAT_NEG) || ((mag_o == SAT_NEG) && frac_any);
    out_rng_o = !nan_o && (huge || (sign_o ? neg_over : pos_over));
  end
endmodule

// File: rtl/cvt_round.sv
module cvt_round
  import cvt_pkg::*;
(
  input  logic             sign_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             rbit_i,
  input  logic             sticky_i,
  input  rmode_e           mode_i,
  output logic [INT_W-1:0] res_o,
  output logic             inexact_o,
  output logic             rounded_o
);
  logic             up;
  logic [INT_W:0]   mag_r;

  always_comb begin
    inexact_o = rbit_i | sticky_i;
    case (mode_i)
      RM_NEAR: up = rbit_i & (sticky_i | mag_i[0]);
      RM_ZERO: up = 1'b0;
      RM_UP:   up = !sign_i & inexact_o;
      default: up = sign_i & inexact_o;
    endcase
    mag_r     = {1'b0, mag_i} + {{INT_W{1'b0}}, up};
    res_o     = sign_i ? (~mag_r[INT_W-1:0] + 1'b1) : mag_r[INT_W-1:0];
    rounded_o = up;
  end
endmodule

// File: rtl/dbl_to_int32_unit.sv
module dbl_to_int32_unit
  import cvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DW-1:0]     operand_i,
  input  logic [1:0]        rmode_i,
  input  logic              trunc_i,
  input  logic              inv_en_i,
  output logic [DW-1:0]     result_o,
  output logic              wr_en_o,
  output logic              exc_req_o,
  output logic [STAT_W-1:0] status_o
);
  logic             sign, nan, snan, out_rng, rbit, sticky;
  logic [INT_W-1:0] mag, rnd_res;
  logic             inexact, rounded;
  rmode_e           mode_eff;

  logic [DW-1:0]    res_q, res_d;
  logic             wr_q, wr_d, exc_q, exc_d;
  stat_t            st_q, st_d;
  logic             invalid;

  cvt_classify u_class (
    .op_i      (operand_i),
    .sign_o    (sign),
    .nan_o     (nan),
    .snan_o    (snan),
    .out_rng_o (out_rng),
    .mag_o     (mag),
    .rbit_o    (rbit),
    .sticky_o  (sticky)
  );

  assign mode_eff = trunc_i ? RM_ZERO : rmode_e'(rmode_i);

  cvt_round u_round (
    .sign_i    (sign),
    .mag_i     (mag),
    .rbit_i    (rbit),
    .sticky_i  (sticky),
    .mode_i    (mode_eff),
    .res_o     (rnd_res),
    .inexact_o (inexact),
    .rounded_o (rounded)
  );

  assign invalid = nan | out_rng;

  always_comb begin
    res_d = res_q;
    st_d  = st_q;
    wr_d  = 1'b0;
    exc_d = 1'b0;
    if (start_i) begin
      if (invalid) begin
        st_d.rounded  = 1'b0;
        st_d.inexact  = 1'b0;
        st_d.inv_conv = 1'b1;
        st_d.inv_any  = 1'b1;
        st_d.inv_snan = st_q.inv_snan | snan;
        st_d.exc_sum  = st_q.exc_sum | inv_en_i;
        exc_d         = inv_en_i;
        wr_d          = !inv_en_i;
        if (!inv_en_i)
          res_d = {SAT_HI, (!nan && !sign) ? SAT_POS : SAT_NEG};
      end else begin
        st_d.rounded = rounded;
        st_d.inexact = inexact;
        wr_d         = 1'b1;
        res_d        = {SAT_HI, rnd_res};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      exc_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      exc_q <= exc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      st_q  <= '0;
    end else if (start_i) begin
      res_q <= res_d;
      st_q  <= st_d;
    end
  end

  assign result_o  = res_q;
  assign wr_en_o   = wr_q;
  assign exc_req_o = exc_q;
  assign status_o  = st_q;
endmodule

// File: rtl/cvt_checker.sv
module cvt_checker
  import cvt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [DW-1:0]     operand_i,
  input logic              inv_en_i,
  input logic [DW-1:0]     result_o,
  input logic              wr_en_o,
  input logic              exc_req_o,
  input logic [STAT_W-1:0] status_o
);
  logic op_nan;
  assign op_nan = (&operand_i[DW-2 -: EXP_W]) && (|operand_i[FRAC_W-1:0]);

  p_one_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_o && exc_req_o));

  p_pulse_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o || exc_req_o) |-> $past(start_i));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_o |-> $stable(result_o));

  p_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (result_o[DW-1 -: 32] == SAT_HI));

  p_trap_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> status_o[5]);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o[5:2] & $past(status_o[5:2])) == $past(status_o[5:2])));

  p_nan_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && inv_en_i && op_nan) |=> (exc_req_o && status_o[2] && status_o[4]));

  p_snan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_nan && !operand_i[FRAC_W-1]) |=> status_o[3]);
endmodule

bind dbl_to_int32_unit cvt_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .operand_i (operand_i),
  .inv_en_i  (inv_en_i),
  .result_o  (result_o),
  .wr_en_o   (wr_en_o),
  .exc_req_o (exc_req_o),
  .status_o  (status_o)
);

// File: tb/test_dbl_to_int32_unit.sv
module test_dbl_to_int32_unit;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [63:0] operand_i;
  logic [1:0]  rmode_i;
  logic        trunc_i;
  logic        inv_en_i;
  logic [63:0] result_o;
  logic        wr_en_o;
  logic        exc_req_o;
  logic [5:0]  status_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [63:0] m_res;
  logic [5:0]  m_stat;

  dbl_to_int32_unit i_dbl_to_int32_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
    .rmode_i(rmode_i), .trunc_i(trunc_i), .inv_en_i(inv_en_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .exc_req_o(exc_req_o),
    .status_o(status_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [71:0] act,
                       input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [63:0] op, input logic [1:0] m,
                         input logic tr, input logic ve);
    real v, f, r, d;
    logic is_nan, snan, outr;
    logic e_wr, e_exc;
    longint li;
    logic [1:0] em;
    string tag;
    v      = $bitstoreal(op);
    is_nan = (&op[62:52]) && (|op[51:0]);
    snan   = is_nan && !op[51];
    outr   = !is_nan && (v > 2147483647.0 || v < -2147483648.0);
    e_wr = 1'b0; e_exc = 1'b0;
    if (is_nan || outr) begin
      m_stat[1:0] = 2'b00;
      m_stat[2] = 1'b1; m_stat[4] = 1'b1;
      if (snan) m_stat[3] = 1'b1;
      if (ve) begin
        m_stat[5] = 1'b1; e_exc = 1'b1;
      end else begin
        e_wr  = 1'b1;
        m_res = (!is_nan && v > 0.0) ? 64'hFFF8_0000_7FFF_FFFF : 64'hFFF8_0000_8000_0000;
      end
      tag = is_nan ? (ve ? "R7/R10/R11" : "R7/R9/R11") : (ve ? "R8/R10/R11" : "R8/R9/R11");
    end else begin
      em = tr ? 2'd1 : m;
      f  = $floor(v);
      case (em)
        2'd0: begin
          d = v - f;
          if (d > 0.5) r = f + 1.0;
          else if (d < 0.5) r = f;
          else begin
            li = longint'(f);
            r  = (li[0] == 1'b0) ? f : f + 1.0;
          end
        end
        2'd1: r = (v >= 0.0) ? f : $ceil(v);
        2'd2: r = $ceil(v);
        default: r = f;
      endcase
      li = longint'(r);
      m_res = {32'hFFF8_0000, li[31:0]};
      m_stat[1] = (r != v);
      m_stat[0] = (v >= 0.0) ? (r > v) : (r < v);
      e_wr = 1'b1;
      tag = tr ? "R3/R5/R6" : "R3/R4/R6";
    end
    @(negedge clk);
    operand_i = op; rmode_i = m; trunc_i = tr; inv_en_i = ve; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({result_o, wr_en_o, exc_req_o, status_o} == {m_res, e_wr, e_exc, m_stat},
          tag, {result_o, wr_en_o, exc_req_o, status_o}, {m_res, e_wr, e_exc, m_stat});
    @(negedge clk);
    check(!wr_en_o && !exc_req_o && result_o == m_res, "R2",
          {result_o, wr_en_o, exc_req_o, status_o}, {m_res, 2'b00, m_stat});
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] specials [0:21];
    rst_n = 1'b0; start_i = 1'b0; operand_i = '0; rmode_i = '0;
    trunc_i = 1'b0; inv_en_i = 1'b0;
    m_res = '0; m_stat = '0;
    repeat (3) @(negedge clk);
    check({result_o, wr_en_o, exc_req_o, status_o} == '0, "R1",
          {result_o, wr_en_o, exc_req_o, status_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check({result_o, wr_en_o, exc_req_o, status_o} == '0, "R1",
          {result_o, wr_en_o, exc_req_o, status_o}, '0);

    for (int k = -160; k <= 160; k++)
      for (int md = 0; md < 4; md++)
        for (int t = 0; t < 2; t++)
          convert($realtobits(real'(k) / 4.0), 2'(md), 1'(t), 1'b0);

    specials[0]  = $realtobits(2147483647.0);
    specials[1]  = $realtobits(2147483647.25);
    specials[2]  = $realtobits(2147483646.5);
    specials[3]  = $realtobits(2147483647.5);
    specials[4]  = $realtobits(2147483648.0);
    specials[5]  = $realtobits(-2147483648.0);
    specials[6]  = $realtobits(-2147483648.5);
    specials[7]  = $realtobits(-2147483647.5);
    specials[8]  = $realtobits(-2147483648.25);
    specials[9]  = $realtobits(1.0e300);
    specials[10] = $realtobits(-1.0e300);
    specials[11] = $realtobits(1.0e-300);
    specials[12] = $realtobits(-1.0e-300);
    specials[13] = 64'h7FF8_0000_0000_0000;
    specials[14] = 64'h7FF0_0000_0000_0001;
    specials[15] = 64'hFFF4_0000_0000_0000;
    specials[16] = 64'h7FF0_0000_0000_0000;
    specials[17] = 64'hFFF0_0000_0000_0000;
    specials[18] = 64'h8000_0000_0000_0000;
    specials[19] = 64'h0000_0000_0000_0001;
    specials[20] = 64'h8000_0000_0000_0001;
    specials[21] = $realtobits(123456789.5);
    for (int ve = 0; ve < 2; ve++)
      for (int i = 0; i < 22; i++)
        for (int md = 0; md < 4; md++)
          for (int t = 0; t < 2; t++) begin
            convert($realtobits(2.5), 2'(md), 1'(t), 1'(ve));
            convert(specials[i], 2'(md), 1'(t), 1'(ve));
          end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule